// File: doc/BRIEF.md
# Triggered Single-Pulse Timer Counter

This block is an up-counting timer driven by a slave-mode controller. The controller picks one trigger source, conditions it, and uses it in one of three ways. The trigger can launch the counter, it can gate the counter on and off, or it can fire a single timed pulse. The external trigger pin passes through a polarity stage and a power-of-two edge prescaler before it can be selected. A group of internal trigger lines is used as-is. In every case, a rising edge of the conditioned signal counts as the trigger event.

The counter counts up to a programmable reload value and then wraps to zero, raising an update event in the cycle where it wraps. In single-pulse mode, the update event clears the enable bit in hardware, so the counter stops at zero. The enable bit can also be set by a trigger edge, so software does not need to arm the counter first. The compare output stays high while the counter is enabled and below the compare value, and this produces one clean pulse per launch. A sticky flag records every qualifying trigger edge until software clears it.

Top module: `pulse_timer`

## Requirements
- R1: After reset, the count, the enable readback, the trigger flag, the update event and the compare output are all 0.
- R2: While enabled with the slave mode off (code 0, and code 3 acts the same), the count rises by 1 on each clock edge. updateEvt is high exactly in the cycles where the count equals autoReload, and the next edge loads 0.
- R3: With singlePulse set, the edge that completes the update event loads 0 into the count and clears the enable readback. The counter then stays at 0 until it is launched again.
- R4: A software write of 0 to the enable takes effect at the sampling edge. The count keeps the value it has after that edge and does not reset.
- R5: In event mode (slave code 2), a rising edge on the selected trigger sets the enable at that edge. Counting starts on the following edge, from the current value.
- R6: In pause mode (slave code 1), the enabled counter advances only on edges where the selected trigger level is high. It holds while that level is low, and the trigger never resets it.
- R7: trigSel code 3'b111 selects the conditioned external trigger, codes 0 to 3 select intTrig[code], and codes 4 to 6 select nothing, so no trigger edge ever occurs.
- R8: With extPol at 0, the external pin is used unchanged. With extPol at 1, it is inverted before edge detection and before level use, so a falling pin edge qualifies.
- R9: With extPsc = n, the external path yields one trigger for every 2^n qualifying pin edges, counted from reset. n = 0 passes every edge.
- R10: Each trigger edge on the selected source sets trigFlag, whatever the slave mode. The flag stays set until flagClr is high at an edge, and a new edge in that same cycle wins over the clear.
- R11: pulseOut is high exactly when the enable readback is 1 and the count is below cmpVal.
- R12: A software enable write has priority over the hardware set from a trigger and the hardware clear at an update event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Active-low synchronous reset |
| enWrite | input | 1 | Software write strobe for the enable bit |
| enWriteVal | input | 1 | Value written to the enable bit |
| singlePulse | input | 1 | Stop and disable at the next update event |
| slaveMode | input | 2 | 0 off, 1 pause (gated), 2 event (start), 3 off |
| trigSel | input | 3 | Trigger source select |
| intTrig | input | NUM_INT | Internal trigger lines |
| extTrig | input | 1 | External trigger pin |
| extPol | input | 1 | External trigger inversion |
| extPsc | input | PSC_W | External edge prescaler exponent |
| flagClr | input | 1 | Write-one clear of the trigger flag |
| autoReload | input | W | Reload (top) value of the counter |
| cmpVal | input | W | Compare threshold for the pulse output |
| count | output | W | Current counter value |
| enable | output | 1 | Enable bit readback |
| trigFlag | output | 1 | Sticky trigger flag |
| updateEvt | output | 1 | Update event strobe |
| pulseOut | output | 1 | Compare output |

## Verification
The hardest state to reach is a prescaled external trigger under inverted polarity. Its effect shows only once the right number of pin edges has gone by, and a polarity change can create a false edge. The bench sets the polarity and an idle pin level while reset is asserted. It then sweeps every prescaler exponent with both polarities, pulsing the pin and clearing the flag after each pulse, so the expected flag follows from the edge index modulo 2^n. A second hard case is a clash between a trigger edge or the update event and a software enable write or flag clear in the same cycle. The bench steps the counter up to the reload value and drives the competing input in exactly that cycle.

// File: rtl/pt_pkg.sv
package pt_pkg;

  typedef enum logic [1:0] {
    SLV_OFF   = 2'd0,
    SLV_PAUSE = 2'd1,
    SLV_EVENT = 2'd2,
    SLV_SPARE = 2'd3
  } slave_mode_e;

  localparam logic [2:0] SEL_EXT = 3'b111;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic run;   // advance counter this edge
    logic wrap;  // load zero this edge (update event)
  } pt_strobe_t;

endpackage

// File: rtl/pt_trig_cond.sv
module pt_trig_cond
  import pt_pkg::*;
#(
  parameter int NUM_INT = 4,
  parameter int PSC_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_INT-1:0] intTrig,
  input  logic               extTrig,
  input  logic               extPol,
  input  logic [PSC_W-1:0]   extPsc,
  input  logic [2:0]         trigSel,
  output logic               trigLvl,
  output logic               trigEdge
);

  localparam int PCNT_W = (1 << PSC_W) - 1;

  logic               extLvl, extPrev, extRaw, extFire;
  logic [PCNT_W-1:0]  pscCnt, pscLimit;
  logic [PCNT_W:0]    limitWide;
  logic [NUM_INT-1:0] intPrev, intRise;

  assign extLvl    = extTrig ^ extPol;
  assign extRaw    = extLvl & ~extPrev;
  assign limitWide = ({{PCNT_W{1'b0}}, 1'b1} << extPsc) - 1'b1;
  assign pscLimit  = limitWide[PCNT_W-1:0];
  assign extFire   = extRaw && (pscCnt >= pscLimit);
  assign intRise   = intTrig & ~intPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extPrev <= 1'b0;
      intPrev <= '0;
      pscCnt  <= '0;
    end else begin
      extPrev <= extLvl;
      intPrev <= intTrig;
      if (extFire)     pscCnt <= '0;
      else if (extRaw) pscCnt <= pscCnt + 1'b1;
    end
  end

  always_comb begin
    trigLvl  = 1'b0;
    trigEdge = 1'b0;
    if (trigSel == SEL_EXT) begin
      trigLvl  = extLvl;
      trigEdge = extFire;
    end else begin
      for (int i = 0; i < NUM_INT; i++) begin
        if (trigSel == 3'(i)) begin
          trigLvl  = intTrig[i];
          trigEdge = intRise[i];
        end
      end
    end
  end

endmodule

// File: rtl/pt_ctrl.sv
module pt_ctrl
  import pt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enWrite,
  input  logic       enWriteVal,
  input  logic       singlePulse,
  input  logic [1:0] slaveMode,
  input  logic       trigLvl,
  input  logic       trigEdge,
  input  logic       flagClr,
  input  logic       atReload,
  output pt_strobe_t strobe,
  output logic       enable,
  output logic       trigFlag,
  output logic       updateEvt
);

  slave_mode_e mode;
  logic        enReg, flagReg, gateOpen;

  assign mode = slave_mode_e'(slaveMode);

  always_comb begin
    gateOpen    = (mode == SLV_PAUSE) ? trigLvl : 1'b1;
    strobe.run  = enReg & gateOpen;
    strobe.wrap = enReg & gateOpen & atReload;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      flagReg <= 1'b0;
    end else begin
      if (enWrite)                             enReg <= enWriteVal;
      else if (mode == SLV_EVENT && trigEdge)  enReg <= 1'b1;
      else if (singlePulse && strobe.wrap)     enReg <= 1'b0;

      if (trigEdge)     flagReg <= 1'b1;
      else if (flagClr) flagReg <= 1'b0;
    end
  end

  assign enable    = enReg;
  assign trigFlag  = flagReg;
  assign updateEvt = strobe.wrap;

endmodule

// File: rtl/pt_datapath.sv
module pt_datapath
  import pt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  pt_strobe_t   strobe,
  input  logic         enable,
  input  logic [W-1:0] autoReload,
  input  logic [W-1:0] cmpVal,
  output logic [W-1:0] count,
  output logic         atReload,
  output logic         pulseOut
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)            cnt <= '0;
    else if (strobe.wrap) cnt <= '0;
    else if (strobe.run)  cnt <= cnt + 1'b1;
  end

  assign count    = cnt;
  assign atReload = (cnt == autoReload);
  assign pulseOut = enable && (cnt < cmpVal);

endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
  import pt_pkg::*;
#(
  parameter int W       = 16,
  parameter int NUM_INT = 4,
  parameter int PSC_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enWrite,
  input  logic               enWriteVal,
  input  logic               singlePulse,
  input  logic [1:0]         slaveMode,
  input  logic [2:0]         trigSel,
  input  logic [NUM_INT-1:0] intTrig,
  input  logic               extTrig,
  input  logic               extPol,
  input  logic [PSC_W-1:0]   extPsc,
  input  logic               flagClr,
  input  logic [W-1:0]       autoReload,
  input  logic [W-1:0]       cmpVal,
  output logic [W-1:0]       count,
  output logic               enable,
  output logic               trigFlag,
  output logic               updateEvt,
  output logic               pulseOut
);

  logic       trigLvl, trigEdge, atReload;
  pt_strobe_t strobe;

  pt_trig_cond #(.NUM_INT(NUM_INT), .PSC_W(PSC_W)) u_trig (
    .clk(clk), .rstN(rstN), .intTrig(intTrig), .extTrig(extTrig),
    .extPol(extPol), .extPsc(extPsc), .trigSel(trigSel),
    .trigLvl(trigLvl), .trigEdge(trigEdge)
  );

  pt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enWrite(enWrite), .enWriteVal(enWriteVal),
    .singlePulse(singlePulse), .slaveMode(slaveMode), .trigLvl(trigLvl),
    .trigEdge(trigEdge), .flagClr(flagClr), .atReload(atReload),
    .strobe(strobe), .enable(enable), .trigFlag(trigFlag),
    .updateEvt(updateEvt)
  );

  pt_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .enable(enable),
    .autoReload(autoReload), .cmpVal(cmpVal), .count(count),
    .atReload(atReload), .pulseOut(pulseOut)
  );

endmodule

// File: rtl/pt_checker.sv
module pt_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         enWrite,
  input logic         singlePulse,
  input logic [1:0]   slaveMode,
  input logic         flagClr,
  input logic [W-1:0] autoReload,
  input logic [W-1:0] count,
  input logic         enable,
  input logic         trigFlag,
  input logic         updateEvt
);

  // R2: free-running step by one below the reload value
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (enable && slaveMode == 2'd0 && count != autoReload)
      |=> (count == $past(count) + 1'b1));

  // R2: update event only at the reload value
  a_r2_update_at_reload: assert property (@(posedge clk) disable iff (!rstN)
    updateEvt |-> (count == autoReload));

  // R3: single pulse stops at zero, enable dropped
  a_r3_single_stop: assert property (@(posedge clk) disable iff (!rstN)
    (updateEvt && singlePulse && !enWrite) |=> (!enable && count == '0));

  // R4: a disabled counter holds its value
  a_r4_hold_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(count));

  // R10: flag stays set without a clear
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (trigFlag && !flagClr) |=> trigFlag);

endmodule

bind pulse_timer pt_checker #(.W(W)) u_pt_checker (
  .clk(clk), .rstN(rstN), .enWrite(enWrite), .singlePulse(singlePulse),
  .slaveMode(slaveMode), .flagClr(flagClr), .autoReload(autoReload),
  .count(count), .enable(enable), .trigFlag(trigFlag), .updateEvt(updateEvt)
);

// File: tb/test_pulse_timer.sv
module test_pulse_timer;
  localparam int W = 8, NI = 4, PW = 2;

  logic          clk = 1'b0, rstN = 1'b0;
  logic          enWrite, enWriteVal, singlePulse, extTrig, extPol, flagClr;
  logic [1:0]    slaveMode;
  logic [2:0]    trigSel;
  logic [NI-1:0] intTrig;
  logic [PW-1:0] extPsc;
  logic [W-1:0]  autoReload, cmpVal, count;
  logic          enable, trigFlag, updateEvt, pulseOut;

  int nChecks = 0, nFails = 0;

  always #10 clk = ~clk;

  pulse_timer #(.W(W), .NUM_INT(NI), .PSC_W(PW)) i_pulse_timer (
    .clk(clk), .rstN(rstN), .enWrite(enWrite), .enWriteVal(enWriteVal),
    .singlePulse(singlePulse), .slaveMode(slaveMode), .trigSel(trigSel),
    .intTrig(intTrig), .extTrig(extTrig), .extPol(extPol), .extPsc(extPsc),
    .flagClr(flagClr), .autoReload(autoReload), .cmpVal(cmpVal),
    .count(count), .enable(enable), .trigFlag(trigFlag),
    .updateEvt(updateEvt), .pulseOut(pulseOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic doReset(input logic pol);
    rstN = 1'b0;
    enWrite = 0; enWriteVal = 0; singlePulse = 0; slaveMode = 2'd0;
    trigSel = 3'd4; intTrig = '0; extPol = pol; extTrig = pol;
    extPsc = '0; flagClr = 0; autoReload = 8'd200; cmpVal = 8'd0;
    cyc(); cyc();
    rstN = 1'b1;
  endtask

  task automatic startSw();
    enWrite = 1; enWriteVal = 1;
    cyc();
    enWrite = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int arList[5] = '{0, 1, 3, 7, 13};
    int spList[3] = '{2, 5, 9};

    // R1: reset state
    doReset(1'b0);
    chk("R1 count", count, 0);
    chk("R1 enable", enable, 0);
    chk("R1 flag", trigFlag, 0);
    chk("R1 update", updateEvt, 0);
    chk("R1 pulse", pulseOut, 0);

    // R2: free-running wrap sweep
    foreach (arList[i]) begin
      doReset(1'b0);
      autoReload = W'(arList[i]);
      startSw();
      for (int k = 0; k < 3 * (arList[i] + 1) + 2; k++) begin
        chk("R2 count", count, k % (arList[i] + 1));
        chk("R2 update", updateEvt, int'((k % (arList[i] + 1)) == arList[i]));
        cyc();
      end
    end

    // R3 + R11: single pulse across compare values
    foreach (spList[i]) begin
      for (int c = 0; c <= spList[i] + 1; c++) begin
        doReset(1'b0);
        singlePulse = 1; autoReload = W'(spList[i]); cmpVal = W'(c);
        startSw();
        for (int k = 0; k <= spList[i]; k++) begin
          chk("R3 count", count, k);
          chk("R11 pulse", pulseOut, int'(k < c));
          cyc();
        end
        for (int k = 0; k < 3; k++) begin
          chk("R3 enable off", enable, 0);
          chk("R3 count zero", count, 0);
          chk("R11 pulse off", pulseOut, 0);
          cyc();
        end
      end
    end

    // R4: software stop holds value
    doReset(1'b0);
    startSw();
    repeat (5) cyc();
    chk("R4 count before", count, 5);
    enWrite = 1; enWriteVal = 0;
    cyc();
    enWrite = 0;
    chk("R4 enable", enable, 0);
    chk("R4 count at stop", count, 6);
    repeat (4) cyc();
    chk("R4 count held", count, 6);

    // R5 + R7: event mode start, unselected line ignored
    doReset(1'b0);
    slaveMode = 2'd2; trigSel = 3'd0;
    repeat (3) cyc();
    chk("R5 idle enable", enable, 0);
    intTrig[1] = 1'b1;
    cyc();
    chk("R7 unselected enable", enable, 0);
    chk("R7 unselected flag", trigFlag, 0);
    intTrig[0] = 1'b1;
    cyc();
    chk("R5 enable set", enable, 1);
    chk("R5 count still", count, 0);
    chk("R10 flag set", trigFlag, 1);
    cyc();
    chk("R5 count 1", count, 1);
    cyc();
    chk("R5 count 2", count, 2);

    // R6: pause mode on internal line
    doReset(1'b0);
    slaveMode = 2'd1; trigSel = 3'd2;
    startSw();
    begin
      int expCnt = 0;
      for (int i = 0; i < 40; i++) begin
        intTrig[2] = ((i * 7) % 5) < 2;
        expCnt += int'(intTrig[2]);
        cyc();
        chk("R6 count", count, expCnt);
      end
    end

    // R6 + R8: pause on inverted external level
    doReset(1'b1);
    slaveMode = 2'd1; trigSel = 3'b111;
    startSw();
    chk("R8 idle level holds", count, 0);
    extTrig = 1'b0;
    repeat (3) cyc();
    chk("R8 inverted level counts", count, 3);

    // R8 + R9: prescaler and polarity sweep
    for (int pol = 0; pol < 2; pol++) begin
      for (int psc = 0; psc < 4; psc++) begin
        doReset(pol[0]);
        extPsc = PW'(psc); trigSel = 3'b111;
        for (int e = 1; e <= 20; e++) begin
          extTrig = ~pol[0];
          cyc();
          chk(pol ? "R8 R9 flag inverted" : "R9 flag", trigFlag,
              int'((e % (1 << psc)) == 0));
          extTrig = pol[0]; flagClr = 1;
          cyc();
          flagClr = 0;
        end
      end
    end

    // R10: sticky flag and set-wins
    doReset(1'b0);
    trigSel = 3'd0;
    intTrig[0] = 1;
    cyc();
    chk("R10 set", trigFlag, 1);
    intTrig[0] = 0;
    repeat (2) cyc();
    chk("R10 sticky", trigFlag, 1);
    intTrig[0] = 1; flagClr = 1;
    cyc();
    chk("R10 set wins", trigFlag, 1);
    intTrig[0] = 0;
    cyc();
    flagClr = 0;
    chk("R10 cleared", trigFlag, 0);

    // R7: empty select codes
    for (int s = 4; s < 7; s++) begin
      doReset(1'b0);
      trigSel = 3'(s); slaveMode = 2'd2;
      intTrig = '1; extTrig = 1;
      cyc();
      chk("R7 no trigger flag", trigFlag, 0);
      chk("R7 no trigger enable", enable, 0);
    end

    // R12: software write wins over update clear
    doReset(1'b0);
    singlePulse = 1; autoReload = 8'd3;
    startSw();
    repeat (3) cyc();
    chk("R12 at reload", updateEvt, 1);
    enWrite = 1; enWriteVal = 1;
    cyc();
    enWrite = 0;
    chk("R12 enable kept", enable, 1);
    chk("R12 wrapped", count, 0);
    cyc();
    chk("R12 runs on", count, 1);

    // R12: software clear wins over trigger set
    doReset(1'b0);
    slaveMode = 2'd2; trigSel = 3'd3;
    intTrig[3] = 1; enWrite = 1; enWriteVal = 0;
    cyc();
    enWrite = 0;
    chk("R12 write over trigger", enable, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule